// File: doc/BRIEF.md
# Keyed Power Domain Sequencer

This block manages a single switchable logic power domain. The domain sits in one of three conditions. Powered with clocks running is the active state. Powered with every domain clock held low is the idle state. Supply fully removed is the off state. Software moves the domain up or down by writing a 4-bit command key. Only two key values mean anything: `0x5` asks for power-up and `0xA` asks for power-down. Every other value is dropped.

The supply reaches the domain through a chain of power switches. The block turns them on one at a time, low index first. Each switch must acknowledge before the next one is enabled. Power-down walks the chain the other way. A transition is finished only when the last switch in the walk has acknowledged. A hardware interlock holds a power-down request pending until software has set the domain's clock-disable bit. A watchdog counter raises a sticky error if a switch acknowledge does not arrive in time.

A configuration word is latched at reset. One bit of it picks whether the domain comes up powered or unpowered. A second bit disables the domain for good. An instance built as the always-on domain ignores both bits and always resets powered. A key that asks for the state the domain is already in is consumed without starting a sequence.

Top module: `pwr_domain_seq`

## Requirements
- R1: During synchronous reset the block samples `cfg_default_on_i`. With it set, the domain leaves reset powered: `status_o`=11 and all of `sw_en_o` set. With it clear, the domain leaves reset off: `status_o`=00 and `sw_en_o`=0. After reset `key_rd_o`=0 and `err_o`=0.
- R2: If `cfg_perm_off_i` is set at reset, the domain stays off (`status_o`=00, `sw_en_o`=0) whatever `cfg_default_on_i` says. Every later key write is dropped and `key_rd_o` stays 0.
- R3: A write with `wr_addr_i`=0 targets the key field in `wr_data_i[3:0]`, and only 0x5 or 0xA is stored. Any other value leaves `key_rd_o` and `status_o` unchanged. A write with `wr_addr_i`=1 loads the clock-disable bit from `wr_data_i[0]`.
- R4: Key 0x5 in the off state moves `status_o` to 01 (turning on). The switches are then enabled one at a time in ascending index order, each after the previous one has acknowledged. `status_o` becomes 11 after the last acknowledge.
- R5: Key 0xA in the on state moves `status_o` to 10 (turning off). The switches are then cleared one at a time in descending index order, each after the previous one has dropped its acknowledge. `status_o` becomes 00 once switch 0 has dropped its acknowledge.
- R6: A 0xA key written while the clock-disable bit is clear is held pending: `key_rd_o` reads 0xA, and `status_o` and `sw_en_o` do not change. The power-down sequence starts on the clock edge after the one that sets the clock-disable bit.
- R7: A stored key is accepted on the clock edge after its write edge if no interlock holds it. On that edge `status_o` changes and `key_rd_o` returns to 0.
- R8: Key writes that arrive while `status_o` is 01 or 10 are dropped. `key_rd_o` stays 0, and once the sequence finishes the state does not change.
- R9: `dom_clk_en_o` is high only in the on state with the clock-disable bit clear. In the on state with the bit set, the domain is idle: `status_o`=11 and `dom_clk_en_o`=0.
- R10: If a sequence step waits more than `TIMEOUT_CYC` cycles for its acknowledge, `err_o` goes high and stays high until reset. The sequence still completes when the acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset; the configuration bits are sampled during it |
| cfg_default_on_i | input | 1 | Configuration: leave reset powered |
| cfg_perm_off_i | input | 1 | Configuration: domain permanently disabled |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = key field, 1 = clock-disable bit |
| wr_data_i | input | 4 | Write data |
| key_rd_o | output | 4 | Key field readback |
| clk_off_rd_o | output | 1 | Clock-disable bit readback |
| dom_clk_en_o | output | 1 | Domain clock gate enable |
| sw_en_o | output | N_SW | Power switch enables |
| sw_ack_i | input | N_SW | Power switch acknowledges |
| status_o | output | 2 | 00 off, 01 turning on, 10 turning off, 11 on |
| err_o | output | 1 | Sticky acknowledge timeout flag |

## Verification
A key write shows up on `key_rd_o` half a cycle after its write edge. An accepted key moves `status_o` one edge later. The bench samples on falling edges so it can check both moments exactly. `dom_clk_en_o` follows a clock-disable write on the same edge the bit is stored. The switch steps depend on the modelled acknowledge delay, so the bench does not fix their cycles. Instead a scoreboard queue holds the expected order of `status_o` and `sw_en_o` values, and a monitor pops an entry at every change. The timeout flag is checked after a window well beyond `TIMEOUT_CYC` with one switch held unacknowledged.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [1:0] {
        PD_OFF     = 2'b00,
        PD_RISING  = 2'b01,
        PD_FALLING = 2'b10,
        PD_ON      = 2'b11
    } pd_mode_e;

    localparam logic [3:0] KEY_WAKE  = 4'h5;
    localparam logic [3:0] KEY_SLEEP = 4'hA;

    localparam logic ADDR_KEY    = 1'b0;
    localparam logic ADDR_CLKOFF = 1'b1;

    function automatic logic key_known(input logic [3:0] k);
        return (k == KEY_WAKE) || (k == KEY_SLEEP);
    endfunction

endpackage

// File: rtl/pds_keyreg.sv
module pds_keyreg
    import pds_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic       wr_addr_i,
    input  logic [3:0] wr_data_i,
    input  logic       busy_i,
    input  logic       lock_i,
    input  logic       consume_i,
    output logic [3:0] key_o,
    output logic       clk_off_o
);

    typedef struct packed {
        logic [3:0] key;
        logic       clk_off;
    } kr_t;

    kr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (consume_i) begin
            r_d.key = 4'h0;
        end else if (wr_en_i && (wr_addr_i == ADDR_KEY) && !busy_i && !lock_i
                     && key_known(wr_data_i)) begin
            r_d.key = wr_data_i;
        end
        if (wr_en_i && (wr_addr_i == ADDR_CLKOFF)) begin
            r_d.clk_off = wr_data_i[0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign key_o     = r_q.key;
    assign clk_off_o = r_q.clk_off;

    AST_KEY_QUIET_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> (r_q.key == 4'h0)); // R8
    AST_KEY_QUIET_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_i |-> (r_q.key == 4'h0)); // R2
    AST_KEY_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.key == 4'h0) || key_known(r_q.key)); // R3

endmodule

// File: rtl/pds_ack_timer.sv
module pds_ack_timer #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic run_i,
    output logic expired_o
);

    generate
        if (LIMIT == 0) begin : g_off
            logic unused_in;
            assign unused_in = ^{clk_i, rst_ni, restart_i, run_i};
            assign expired_o = 1'b0;
        end else begin : g_on
            localparam int unsigned CW = $clog2(LIMIT + 1);
            localparam logic [CW-1:0] CMAX = CW'(LIMIT);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (restart_i)                  cnt_d = '0;
                else if (run_i && cnt_q != CMAX) cnt_d = cnt_q + CW'(1);
            end

            always_ff @(posedge clk_i) begin
                if (!rst_ni) cnt_q <= '0;
                else         cnt_q <= cnt_d;
            end

            assign expired_o = run_i && (cnt_q == CMAX);

            AST_TIMER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
                restart_i |=> (cnt_q == '0)); // R10
        end
    endgenerate

endmodule

// File: rtl/pds_switch_chain.sv
module pds_switch_chain #(
    parameter int unsigned N_SW = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rst_on_i,
    input  logic            start_up_i,
    input  logic            start_down_i,
    input  logic [N_SW-1:0] sw_ack_i,
    output logic [N_SW-1:0] sw_en_o,
    output logic            done_o,
    output logic            step_o,
    output logic            wait_o
);

    localparam int unsigned IW = (N_SW > 1) ? $clog2(N_SW) : 1;
    localparam logic [IW-1:0] LAST = IW'(N_SW - 1);

    typedef struct packed {
        logic            active;
        logic            up;
        logic [IW-1:0]   idx;
        logic [N_SW-1:0] en;
    } ch_t;

    ch_t r_d, r_q;

    logic [N_SW-1:0] settled;
    logic            hit;
    logic            at_end;
    logic [IW-1:0]   nxt;

    generate
        for (genvar g = 0; g < N_SW; g++) begin : g_settle
            assign settled[g] = (sw_ack_i[g] == r_q.en[g]);
        end
    endgenerate

    assign hit    = settled[r_q.idx];
    assign at_end = r_q.up ? (r_q.idx == LAST) : (r_q.idx == '0);

    always_comb begin
        r_d    = r_q;
        nxt    = r_q.idx;
        done_o = 1'b0;
        step_o = 1'b0;
        if (start_up_i) begin
            r_d.active = 1'b1;
            r_d.up     = 1'b1;
            r_d.idx    = '0;
            r_d.en[0]  = 1'b1;
            step_o     = 1'b1;
        end else if (start_down_i) begin
            r_d.active   = 1'b1;
            r_d.up       = 1'b0;
            r_d.idx      = LAST;
            r_d.en[LAST] = 1'b0;
            step_o       = 1'b1;
        end else if (r_q.active && hit) begin
            step_o = 1'b1;
            if (at_end) begin
                r_d.active = 1'b0;
                done_o     = 1'b1;
            end else begin
                nxt         = r_q.up ? (r_q.idx + IW'(1)) : (r_q.idx - IW'(1));
                r_d.idx     = nxt;
                r_d.en[nxt] = r_q.up;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.active <= 1'b0;
            r_q.up     <= 1'b0;
            r_q.idx    <= '0;
            r_q.en     <= rst_on_i ? '1 : '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sw_en_o = r_q.en;
    assign wait_o  = r_q.active && !hit;

    AST_ONE_SWITCH_PER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(r_q.en ^ $past(r_q.en)) <= 1); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!r_q.active && !start_up_i && !start_down_i) |=> $stable(r_q.en)); // R5

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
    import pds_pkg::*;
#(
    parameter int unsigned N_SW        = 4,
    parameter int unsigned TIMEOUT_CYC = 64,
    parameter bit          ALWAYS_ON   = 1'b0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cfg_default_on_i,
    input  logic            cfg_perm_off_i,
    input  logic            wr_en_i,
    input  logic            wr_addr_i,
    input  logic [3:0]      wr_data_i,
    output logic [3:0]      key_rd_o,
    output logic            clk_off_rd_o,
    output logic            dom_clk_en_o,
    output logic [N_SW-1:0] sw_en_o,
    input  logic [N_SW-1:0] sw_ack_i,
    output logic [1:0]      status_o,
    output logic            err_o
);

    typedef struct packed {
        pd_mode_e mode;
        logic     locked;
        logic     err;
    } top_t;

    top_t r_d, r_q;

    logic       boot_on;
    logic       boot_lock;
    logic [3:0] key;
    logic       clk_off;
    logic       start_up, start_down, consume, busy;
    logic       chain_done, chain_step, chain_wait, expired;

    assign boot_lock = cfg_perm_off_i && !ALWAYS_ON;
    assign boot_on   = ALWAYS_ON || (cfg_default_on_i && !cfg_perm_off_i);

    assign busy       = (r_q.mode == PD_RISING) || (r_q.mode == PD_FALLING);
    assign start_up   = (r_q.mode == PD_OFF) && (key == KEY_WAKE) && !r_q.locked;
    assign start_down = (r_q.mode == PD_ON) && (key == KEY_SLEEP) && clk_off;
    assign consume    = start_up || start_down
                      || ((r_q.mode == PD_OFF) && (key == KEY_SLEEP))
                      || ((r_q.mode == PD_ON)  && (key == KEY_WAKE));

    pds_keyreg u_keyreg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .busy_i    (busy),
        .lock_i    (r_q.locked),
        .consume_i (consume),
        .key_o     (key),
        .clk_off_o (clk_off)
    );

    pds_switch_chain #(.N_SW(N_SW)) u_chain (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .rst_on_i     (boot_on),
        .start_up_i   (start_up),
        .start_down_i (start_down),
        .sw_ack_i     (sw_ack_i),
        .sw_en_o      (sw_en_o),
        .done_o       (chain_done),
        .step_o       (chain_step),
        .wait_o       (chain_wait)
    );

    pds_ack_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (chain_step),
        .run_i     (chain_wait),
        .expired_o (expired)
    );

    always_comb begin
        r_d     = r_q;
        r_d.err = r_q.err || expired;
        if (start_up) begin
            r_d.mode = PD_RISING;
        end else if (start_down) begin
            r_d.mode = PD_FALLING;
        end else if (chain_done) begin
            r_d.mode = (r_q.mode == PD_RISING) ? PD_ON : PD_OFF;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.mode   <= boot_on ? PD_ON : PD_OFF;
            r_q.locked <= boot_lock;
            r_q.err    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign status_o     = r_q.mode;
    assign err_o        = r_q.err;
    assign key_rd_o     = key;
    assign clk_off_rd_o = clk_off;
    assign dom_clk_en_o = (r_q.mode == PD_ON) && !clk_off;

    AST_CLK_NEEDS_POWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dom_clk_en_o |-> (&sw_en_o)); // R9
    AST_INTERLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((r_q.mode == PD_ON) && !clk_off) |=> (r_q.mode != PD_FALLING)); // R6
    AST_LOCK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.locked |-> ((r_q.mode == PD_OFF) && (sw_en_o == '0))); // R2
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.err |=> r_q.err); // R10
    AST_UP_ALL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(r_q.mode) == PD_RISING && r_q.mode == PD_ON) |-> (&sw_en_o)); // R4
    AST_DOWN_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(r_q.mode) == PD_FALLING && r_q.mode == PD_OFF) |-> (sw_en_o == '0)); // R5

endmodule

// File: tb/pwr_domain_seq_bench.sv
module pwr_domain_seq_bench;

    localparam int unsigned NS = 4;
    localparam int unsigned TO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_on = 1'b0, cfg_off = 1'b0;
    logic          wr_en = 1'b0, wr_addr = 1'b0;
    logic [3:0]    wr_data = 4'h0;
    logic [3:0]    key_rd;
    logic          clk_off_rd, clk_en, err;
    logic [NS-1:0] sw_en, sw_ack = '0, st1 = '0, stuck = '0;
    logic [1:0]    status;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    logic [1:0]    exp_st_q[$];
    logic [NS-1:0] exp_sw_q[$];
    logic [1:0]    prev_st = '0;
    logic [NS-1:0] prev_sw = '0;
    logic          prev_rst = 1'b0;

    always #2 clk = ~clk;

    pwr_domain_seq #(.N_SW(NS), .TIMEOUT_CYC(TO), .ALWAYS_ON(1'b0)) u_pwr_domain_seq (
        .clk_i(clk), .rst_ni(rst_n), .cfg_default_on_i(cfg_on), .cfg_perm_off_i(cfg_off),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .key_rd_o(key_rd), .clk_off_rd_o(clk_off_rd), .dom_clk_en_o(clk_en),
        .sw_en_o(sw_en), .sw_ack_i(sw_ack), .status_o(status), .err_o(err)
    );

    // switch model: acknowledge trails enable by two falling edges
    always @(negedge clk) begin
        st1    <= sw_en;
        sw_ack <= st1 & ~stuck;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: every change of status or switch enables pops the scoreboard
    always @(negedge clk) begin
        if (rst_n && prev_rst) begin
            if (status != prev_st) begin
                if (exp_st_q.size() == 0) chk(1'b0, "R4/R5 status order", status, 4'hF);
                else begin
                    logic [1:0] e;
                    e = exp_st_q.pop_front();
                    chk(status == e, "R4/R5 status order", status, e);
                end
            end
            if (sw_en != prev_sw) begin
                if (exp_sw_q.size() == 0) chk(1'b0, "R4/R5 switch order", sw_en, 4'hF);
                else begin
                    logic [NS-1:0] e;
                    e = exp_sw_q.pop_front();
                    chk(sw_en == e, "R4/R5 switch order", sw_en, e);
                end
            end
        end
        prev_st  <= status;
        prev_sw  <= sw_en;
        prev_rst <= rst_n;
    end

    task automatic wr(input logic a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_st(input logic [1:0] v, input string req);
        int i = 0;
        while (status != v && i < 300) begin
            @(negedge clk);
            i++;
        end
        chk(status == v, req, status, v);
    endtask

    task automatic do_reset(input logic on, input logic off);
        @(negedge clk);
        cfg_on = on; cfg_off = off; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push_up();
        exp_st_q.push_back(2'b01); exp_st_q.push_back(2'b11);
        exp_sw_q.push_back(4'b0001); exp_sw_q.push_back(4'b0011);
        exp_sw_q.push_back(4'b0111); exp_sw_q.push_back(4'b1111);
    endtask

    task automatic push_down();
        exp_st_q.push_back(2'b10); exp_st_q.push_back(2'b00);
        exp_sw_q.push_back(4'b0111); exp_sw_q.push_back(4'b0011);
        exp_sw_q.push_back(4'b0001); exp_sw_q.push_back(4'b0000);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset off
        do_reset(1'b0, 1'b0);
        chk(status == 2'b00, "R1 status", status, 0);
        chk(sw_en == '0, "R1 sw_en", sw_en, 0);
        chk(key_rd == 4'h0 && err == 1'b0, "R1 key/err", {key_rd, err}, 0);
        chk(clk_en == 1'b0, "R9 clk off when unpowered", clk_en, 0);

        // R3: unknown keys dropped
        wr(1'b0, 4'h3);
        chk(key_rd == 4'h0, "R3 key 0x3", key_rd, 0);
        wr(1'b0, 4'hF);
        chk(key_rd == 4'h0, "R3 key 0xF", key_rd, 0);
        repeat (4) @(negedge clk);
        chk(status == 2'b00 && sw_en == '0, "R3 no change", status, 0);

        // R4: power-up, clocks enabled
        push_up();
        wr(1'b0, 4'h5);
        wait_st(2'b11, "R4 reach on");
        chk(clk_en == 1'b1, "R9 clock in active", clk_en, 1);
        chk(key_rd == 4'h0, "R7 key cleared", key_rd, 0);

        // R6: power-down pending until clocks disabled
        wr(1'b0, 4'hA);
        chk(key_rd == 4'hA && status == 2'b11, "R6 pending", {key_rd, 2'b00} | status, 8'h2B);
        repeat (5) @(negedge clk);
        chk(status == 2'b11 && sw_en == 4'hF, "R6 held", sw_en, 4'hF);
        chk(key_rd == 4'hA, "R6 readback", key_rd, 4'hA);
        push_down();
        wr(1'b1, 4'h1);
        chk(clk_en == 1'b0 && status == 2'b11, "R6 clock off first", {clk_en, status}, 3);
        @(negedge clk);
        chk(status == 2'b10, "R6 start after clk-dis", status, 2);
        wait_st(2'b00, "R5 reach off");

        // R8: keys ignored during transition
        push_up();
        wr(1'b0, 4'h5);
        chk(status == 2'b00 && key_rd == 4'h5, "R7 stored", key_rd, 5);
        @(negedge clk);
        chk(status == 2'b01 && key_rd == 4'h0, "R7 accepted", status, 1);
        wr(1'b0, 4'hA);
        chk(key_rd == 4'h0, "R8 key dropped", key_rd, 0);
        wait_st(2'b11, "R4 reach on again");
        repeat (10) @(negedge clk);
        chk(status == 2'b11, "R8 no later power-down", status, 3);
        chk(clk_en == 1'b0, "R9 idle keeps clock low", clk_en, 0);
        wr(1'b1, 4'h0);
        chk(clk_en == 1'b1, "R9 clock back on", clk_en, 1);

        // R7: latency of accepted power-down
        wr(1'b1, 4'h1);
        push_down();
        wr(1'b0, 4'hA);
        chk(status == 2'b11 && key_rd == 4'hA, "R7 stored down", key_rd, 4'hA);
        @(negedge clk);
        chk(status == 2'b10 && key_rd == 4'h0, "R7 accepted down", status, 2);
        wait_st(2'b00, "R5 reach off again");

        // R10: timeout with switch 2 stuck
        stuck = 4'b0100;
        exp_st_q.push_back(2'b01);
        exp_sw_q.push_back(4'b0001); exp_sw_q.push_back(4'b0011); exp_sw_q.push_back(4'b0111);
        wr(1'b0, 4'h5);
        repeat (TO + 30) @(negedge clk);
        chk(err == 1'b1, "R10 err set", err, 1);
        chk(status == 2'b01 && sw_en == 4'b0111, "R10 still waiting", sw_en, 4'h7);
        exp_st_q.push_back(2'b11); exp_sw_q.push_back(4'b1111);
        stuck = '0;
        wait_st(2'b11, "R10 completes");
        chk(err == 1'b1, "R10 sticky", err, 1);

        // R1: reset powered
        do_reset(1'b1, 1'b0);
        chk(status == 2'b11 && sw_en == 4'hF, "R1 default on", sw_en, 4'hF);
        chk(err == 1'b0 && clk_en == 1'b1, "R1 err clear", {err, clk_en}, 1);

        // R2: permanent disable
        do_reset(1'b1, 1'b1);
        chk(status == 2'b00 && sw_en == '0, "R2 forced off", sw_en, 0);
        wr(1'b0, 4'h5);
        chk(key_rd == 4'h0, "R2 key dropped", key_rd, 0);
        repeat (10) @(negedge clk);
        chk(status == 2'b00 && sw_en == '0, "R2 stays off", status, 0);

        chk(exp_st_q.size() == 0 && exp_sw_q.size() == 0, "R4/R5 scoreboard drained",
            exp_st_q.size() + exp_sw_q.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule